// File: doc/BRIEF.md
# Interval Timer Host Bus Port

This block is the processor-facing side of a three-channel interval timer. A bus access is a single clock cycle in which chip select is low together with the write strobe or the read strobe. Address values 0 to 2 reach the three counters. Address 3 reaches the control register. Each control byte names one counter in its top two bits. Each counter therefore takes its settings independently, and the counters can be programmed in any order.

For every counter the port keeps a write byte position and a read byte position, and it keeps a readback holding register. A counter can be set to low-byte-only access, high-byte-only access, or a two-byte pair sent low byte first. The holding register follows the live count from the counting element. A freeze command stops it at the present value until a complete readback has finished.

The port drives three outputs per counter: a strobe that marks a newly written count value, the count value itself, and the mode fields. Read data returns on an 8-bit bus that has its own output enable. The counting datapath is outside this block.

Top module: `timer_cpu_port`

## Requirements
- R1: While cs_n is high, rd_n and wr_n do nothing: no strobe pulses, dout_oe stays low, and no byte position moves.
- R2: A write to address 3 is a control byte with this layout: [7:6] counter, [5:4] access (00 freeze, 01 low only, 10 high only, 11 low then high), [3:1] mode, [0] bcd. When the access field is nonzero and the counter field is 0 to 2, the write stores access, mode and bcd for that counter. cfg_strobe for that counter is high for exactly the next cycle. A counter field of 3 changes nothing.
- R3: Count writes depend on the access setting. Low only loads {8'h00,din}. High only loads {din,8'h00}. Two-byte access takes the low byte first and the high byte second. cr_o updates, and load_o for that counter is high for one cycle, in the cycle after the write that completes the value and in no other cycle.
- R4: Accesses to other counters may come between the two bytes of one counter's pair without disturbing that counter's byte position.
- R5: A read cycle to address 0 to 2 drives dout_oe high in that same cycle and places the selected byte on dout. When the counter is not frozen, the byte comes from the live count as sampled one cycle earlier.
- R6: A freeze command (access field 00) captures the live count in its own cycle. Reads then return the captured value until the final byte of a readback. After that, reads follow the live count again.
- R7: A freeze command sent to a counter that is already frozen and not yet fully read is ignored.
- R8: With low-only access every read returns the low byte. With high-only access every read returns the high byte.
- R9: The read byte position and the write byte position of one counter advance independently.
- R10: A control byte that configures a counter resets both of its byte positions to low and cancels any freeze on it.
- R11: A read at address 3 keeps dout_oe low and dout at 0.
- R12: After reset every counter has two-byte access, mode 0, bcd 0 and a count value of 0, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Counter 0-2 or control register (3) |
| din | input | 8 | Write data |
| ce_cnt | input | 48 | Live count of each counter, 16 bits per counter |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data valid; low means the bus is released |
| cfg_strobe | output | 3 | One-cycle pulse per counter after a control byte |
| mode_o | output | 9 | Mode field, 3 bits per counter |
| bcd_o | output | 3 | BCD flag per counter |
| cr_o | output | 48 | Written count value, 16 bits per counter |
| load_o | output | 3 | One-cycle pulse per counter when a new count value is complete |

## Verification
The bench interleaves the two bytes of one counter with bytes for other counters. A design that shared a single byte position across counters would assemble the wrong value. It mixes reads and writes on the same counter; a shared read/write position would swap bytes in both directions. It changes the live count between the two byte reads of a frozen counter, and it sends a second freeze command. A design with a leaky or re-armable holding register would return a torn or refreshed value. A control byte is written in the middle of a pair and over a pending freeze, to catch stale positions and stale freezes. Strobes are issued with chip select high, and reads are made at the control address, to catch ungated decoding and a bus that drives when it should not.

// File: rtl/timer_cpu_pkg.sv
package timer_cpu_pkg;

  typedef enum logic [1:0] {
    ACC_FREEZE = 2'b00,
    ACC_LO     = 2'b01,
    ACC_HI     = 2'b10,
    ACC_PAIR   = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_t;

  function automatic logic [7:0] pick_byte(input logic [15:0] v, input logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction

  function automatic logic read_hi(input acc_e acc, input logic pos);
    return (acc == ACC_HI) || ((acc == ACC_PAIR) && pos);
  endfunction

  function automatic logic read_last(input acc_e acc, input logic pos);
    return (acc != ACC_PAIR) || pos;
  endfunction

  function automatic logic [15:0] place_single(input acc_e acc, input logic [7:0] b);
    return (acc == ACC_HI) ? {b, 8'h00} : {8'h00, b};
  endfunction

endpackage

// File: rtl/timer_bus_decode.sv
module timer_bus_decode
  import timer_cpu_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 2
) (
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [NCH-1:0]    wr_cnt,
  output logic [NCH-1:0]    rd_cnt,
  output logic [NCH-1:0]    cfg_hit,
  output logic [NCH-1:0]    frz_hit
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NCH);

  logic wr_cyc, rd_cyc, ctl_wr;
  ctl_t ctl;

  assign wr_cyc = !cs_n && !wr_n;
  assign rd_cyc = !cs_n && !rd_n && wr_n;
  assign ctl_wr = wr_cyc && (addr == CTL_ADDR);
  assign ctl    = ctl_t'(din);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic sel_me;
    assign sel_me     = ctl_wr && (ctl.sel == 2'(i));
    assign wr_cnt[i]  = wr_cyc && (addr == ADDR_W'(i));
    assign rd_cnt[i]  = rd_cyc && (addr == ADDR_W'(i));
    assign cfg_hit[i] = sel_me && (ctl.acc != ACC_FREEZE);
    assign frz_hit[i] = sel_me && (ctl.acc == ACC_FREEZE);
  end

endmodule

// File: rtl/timer_chan_port.sv
module timer_chan_port
  import timer_cpu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cnt,
  input  logic             rd_cnt,
  input  logic             cfg_hit,
  input  logic             frz_hit,
  input  logic [7:0]       din,
  input  logic [CNT_W-1:0] ce_val,
  output logic [CNT_W-1:0] cr,
  output logic             load,
  output logic             cfg_stb,
  output logic [2:0]       mode,
  output logic             bcd,
  output logic [7:0]       rd_byte,
  output logic             frozen,
  output logic [CNT_W-1:0] hold
);
  acc_e       acc;
  logic       wr_pos, rd_pos;
  logic [7:0] lo_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= ACC_PAIR;
      mode    <= 3'd0;
      bcd     <= 1'b0;
      wr_pos  <= 1'b0;
      rd_pos  <= 1'b0;
      frozen  <= 1'b0;
      cr      <= '0;
      lo_keep <= 8'h00;
      load    <= 1'b0;
      cfg_stb <= 1'b0;
    end else begin
      load    <= 1'b0;
      cfg_stb <= 1'b0;
      if (cfg_hit) begin
        acc     <= acc_e'(din[5:4]);
        mode    <= din[3:1];
        bcd     <= din[0];
        wr_pos  <= 1'b0;
        rd_pos  <= 1'b0;
        frozen  <= 1'b0;
        cfg_stb <= 1'b1;
      end else begin
        if (frz_hit && !frozen) frozen <= 1'b1;
        if (wr_cnt) begin
          if (acc == ACC_PAIR) begin
            if (!wr_pos) begin
              lo_keep <= din;
              wr_pos  <= 1'b1;
            end else begin
              cr     <= {din, lo_keep};
              wr_pos <= 1'b0;
              load   <= 1'b1;
            end
          end else begin
            cr   <= place_single(acc, din);
            load <= 1'b1;
          end
        end
        if (rd_cnt) begin
          if (read_last(acc, rd_pos)) begin
            rd_pos <= 1'b0;
            frozen <= 1'b0;
          end else begin
            rd_pos <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= '0;
    else if (!frozen) hold <= ce_val;
  end

  assign rd_byte = pick_byte(hold, read_hi(acc, rd_pos));

endmodule

// File: rtl/timer_rd_mux.sv
module timer_rd_mux #(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0]   rd_cnt,
  input  logic [NCH*8-1:0] rd_bytes,
  output logic [7:0]       dout,
  output logic             dout_oe
);
  always_comb begin
    dout = 8'h00;
    for (int i = 0; i < NCH; i++) begin
      if (rd_cnt[i]) dout = dout | rd_bytes[i*8 +: 8];
    end
  end
  assign dout_oe = |rd_cnt;
endmodule

// File: rtl/timer_cpu_port.sv
module timer_cpu_port #(
  parameter int NCH    = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = $clog2(NCH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         din,
  input  logic [NCH*CNT_W-1:0] ce_cnt,
  output logic [7:0]         dout,
  output logic               dout_oe,
  output logic [NCH-1:0]     cfg_strobe,
  output logic [NCH*3-1:0]   mode_o,
  output logic [NCH-1:0]     bcd_o,
  output logic [NCH*CNT_W-1:0] cr_o,
  output logic [NCH-1:0]     load_o
);
  logic [NCH-1:0]       wr_cnt, rd_cnt, cfg_hit, frz_hit;
  logic [NCH*8-1:0]     rd_bytes;
  logic [NCH-1:0]       frozen_w;
  logic [NCH*CNT_W-1:0] hold_w;

  timer_bus_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
    .wr_cnt(wr_cnt), .rd_cnt(rd_cnt), .cfg_hit(cfg_hit), .frz_hit(frz_hit)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    timer_chan_port #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_cnt(wr_cnt[i]), .rd_cnt(rd_cnt[i]),
      .cfg_hit(cfg_hit[i]), .frz_hit(frz_hit[i]),
      .din(din), .ce_val(ce_cnt[i*CNT_W +: CNT_W]),
      .cr(cr_o[i*CNT_W +: CNT_W]), .load(load_o[i]),
      .cfg_stb(cfg_strobe[i]), .mode(mode_o[i*3 +: 3]), .bcd(bcd_o[i]),
      .rd_byte(rd_bytes[i*8 +: 8]),
      .frozen(frozen_w[i]), .hold(hold_w[i*CNT_W +: CNT_W])
    );
  end

  timer_rd_mux #(.NCH(NCH)) u_mux (
    .rd_cnt(rd_cnt), .rd_bytes(rd_bytes), .dout(dout), .dout_oe(dout_oe)
  );

endmodule

// File: rtl/timer_cpu_port_chk.sv
module timer_cpu_port_chk #(
  parameter int NCH    = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 rd_n,
  input logic                 wr_n,
  input logic [ADDR_W-1:0]    addr,
  input logic [3:0]           din_hi,
  input logic                 dout_oe,
  input logic [NCH-1:0]       cfg_strobe,
  input logic [NCH-1:0]       load_o,
  input logic [NCH-1:0]       frozen_w,
  input logic [NCH*CNT_W-1:0] hold_w
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NCH);

  // R1: no strobes follow a deselected cycle
  p_cs_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (load_o == '0 && cfg_strobe == '0));

  // R1, R11: bus only driven on a selected counter read
  p_oe_decode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!cs_n && !rd_n && wr_n && addr != CTL_ADDR));

  // R2: a config strobe has a matching control write behind it
  p_cfg_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_strobe != '0) |-> $past(!cs_n && !wr_n && addr == CTL_ADDR &&
                                 din_hi[3:2] != 2'b11 && din_hi[1:0] != 2'b00));

  // R2: one counter per control byte
  p_cfg_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_strobe));

  // R3: one load per write cycle
  p_load_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_o));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R3: a load comes from a write to that counter
    p_load_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_o[i] |-> $past(!cs_n && !wr_n && addr == ADDR_W'(i)));
    // R6: frozen holding value does not move
    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen_w[i] && $past(frozen_w[i])) |-> $stable(hold_w[i*CNT_W +: CNT_W]));
  end

endmodule

bind timer_cpu_port timer_cpu_port_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .addr(addr), .din_hi(din[7:4]), .dout_oe(dout_oe),
  .cfg_strobe(cfg_strobe), .load_o(load_o),
  .frozen_w(frozen_w), .hold_w(hold_w)
);

// File: tb/tb_timer_cpu_port.sv
module tb_timer_cpu_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  din = 8'h00;
  logic [47:0] ce_cnt = '0;
  logic [7:0]  dout;
  logic        dout_oe;
  logic [2:0]  cfg_strobe, bcd_o, load_o;
  logic [8:0]  mode_o;
  logic [47:0] cr_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] q;
  logic       oe;

  always #5 clk = ~clk;

  timer_cpu_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .ce_cnt(ce_cnt), .dout(dout), .dout_oe(dout_oe),
    .cfg_strobe(cfg_strobe), .mode_o(mode_o), .bcd_o(bcd_o), .cr_o(cr_o),
    .load_o(load_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle; returns at the next falling edge with outputs settled
  task automatic cyc(input logic c, input logic r, input logic w,
                     input logic [1:0] a, input logic [7:0] d,
                     output logic [7:0] qq, output logic qoe);
    @(negedge clk);
    cs_n = c; rd_n = r; wr_n = w; addr = a; din = d;
    #1;
    qq = dout; qoe = dout_oe;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] t; logic te;
    cyc(1'b0, 1'b1, 1'b0, a, d, t, te);
  endtask

  task automatic rd(input logic [1:0] a);
    cyc(1'b0, 1'b0, 1'b1, a, 8'h00, q, oe);
  endtask

  function automatic logic [15:0] cr_of(input int ch);
    return cr_o[ch*16 +: 16];
  endfunction

  task automatic set_ce(input int ch, input logic [15:0] v);
    @(negedge clk);
    ce_cnt[ch*16 +: 16] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R12 oe", {15'd0, dout_oe}, 16'd0);
    check("R12 strobes", {10'd0, load_o, cfg_strobe}, 16'd0);
    check("R12 mode/bcd", {4'd0, bcd_o, mode_o}, 16'd0);
    check("R12 cr", cr_o[15:0] | cr_o[31:16] | cr_o[47:32], 16'd0);
    wr(2'd0, 8'h21); wr(2'd0, 8'h43);
    check("R12 default pair", cr_of(0), 16'h4321);
  endtask

  task automatic t_config;
    wr(2'd3, 8'b01_11_101_1);
    check("R2 strobe", {13'd0, cfg_strobe}, 16'h0002);
    check("R2 mode", {13'd0, mode_o[5:3]}, 16'd5);
    check("R2 bcd", {15'd0, bcd_o[1]}, 16'd1);
    @(negedge clk);
    check("R2 strobe one cycle", {13'd0, cfg_strobe}, 16'd0);
    wr(2'd3, 8'b11_01_011_1);
    check("R2 sel3 ignored strobe", {13'd0, cfg_strobe}, 16'd0);
    check("R2 sel3 ignored mode", {7'd0, mode_o}, 16'h0028);
  endtask

  task automatic t_writes;
    wr(2'd3, 8'b00_11_010_0);
    wr(2'd0, 8'h34);
    check("R3 no load after first byte", {13'd0, load_o}, 16'd0);
    wr(2'd0, 8'h12);
    check("R3 load pair", {13'd0, load_o}, 16'h0001);
    check("R3 cr pair", cr_of(0), 16'h1234);
    @(negedge clk);
    check("R3 load one cycle", {13'd0, load_o}, 16'd0);
    wr(2'd3, 8'b10_01_000_0);
    wr(2'd2, 8'hAB);
    check("R3 lo only load", {13'd0, load_o}, 16'h0004);
    check("R3 lo only cr", cr_of(2), 16'h00AB);
    wr(2'd3, 8'b10_10_000_0);
    wr(2'd2, 8'hCD);
    check("R3 hi only cr", cr_of(2), 16'hCD00);
  endtask

  task automatic t_interleave;
    wr(2'd3, 8'b00_11_000_0);
    wr(2'd3, 8'b01_11_000_0);
    wr(2'd0, 8'h78);
    wr(2'd1, 8'h11);
    wr(2'd2, 8'hEE);
    wr(2'd0, 8'h56);
    check("R4 ch0 load", {13'd0, load_o}, 16'h0001);
    check("R4 ch0 value", cr_of(0), 16'h5678);
    wr(2'd1, 8'h22);
    check("R4 ch1 value", cr_of(1), 16'h2211);
  endtask

  task automatic t_read;
    set_ce(0, 16'hBEEF);
    rd(2'd0);
    check("R5 oe", {15'd0, oe}, 16'd1);
    check("R5 lo byte", {8'd0, q}, 16'h00EF);
    rd(2'd0);
    check("R5 hi byte", {8'd0, q}, 16'h00BE);
  endtask

  task automatic t_freeze;
    set_ce(0, 16'h1357);
    wr(2'd3, 8'b00_00_0000);
    ce_cnt[15:0] = 16'h2468;
    rd(2'd0);
    check("R6 frozen lo", {8'd0, q}, 16'h0057);
    ce_cnt[15:0] = 16'hAAAA;
    rd(2'd0);
    check("R6 frozen hi", {8'd0, q}, 16'h0013);
    rd(2'd0);
    check("R6 follows after readback", {8'd0, q}, 16'h00AA);
    rd(2'd0);
  endtask

  task automatic t_refreeze;
    set_ce(1, 16'h0102);
    wr(2'd3, 8'b01_00_0000);
    ce_cnt[31:16] = 16'h0304;
    set_ce(1, 16'h0304);
    wr(2'd3, 8'b01_00_0000);
    rd(2'd1);
    check("R7 second freeze ignored lo", {8'd0, q}, 16'h0002);
    rd(2'd1);
    check("R7 second freeze ignored hi", {8'd0, q}, 16'h0001);
    rd(2'd1);
    check("R7 released", {8'd0, q}, 16'h0004);
    rd(2'd1);
  endtask

  task automatic t_single_read;
    wr(2'd3, 8'b10_01_000_0);
    set_ce(2, 16'h5AA5);
    rd(2'd2);
    check("R8 lo only first", {8'd0, q}, 16'h00A5);
    rd(2'd2);
    check("R8 lo only second", {8'd0, q}, 16'h00A5);
    wr(2'd3, 8'b10_10_000_0);
    rd(2'd2);
    check("R8 hi only first", {8'd0, q}, 16'h005A);
    rd(2'd2);
    check("R8 hi only second", {8'd0, q}, 16'h005A);
  endtask

  task automatic t_mixed_dir;
    wr(2'd3, 8'b00_11_000_0);
    set_ce(0, 16'hC0DE);
    rd(2'd0);
    check("R9 read lo", {8'd0, q}, 16'h00DE);
    wr(2'd0, 8'h99);
    check("R9 no load yet", {13'd0, load_o}, 16'd0);
    rd(2'd0);
    check("R9 read hi", {8'd0, q}, 16'h00C0);
    wr(2'd0, 8'h88);
    check("R9 write pair", cr_of(0), 16'h8899);
  endtask

  task automatic t_reconfig;
    wr(2'd3, 8'b01_11_000_0);
    wr(2'd1, 8'h44);
    wr(2'd3, 8'b01_11_000_0);
    wr(2'd1, 8'h66);
    check("R10 pair restarted", {13'd0, load_o}, 16'd0);
    wr(2'd1, 8'h77);
    check("R10 value", cr_of(1), 16'h7766);
    set_ce(1, 16'h1111);
    wr(2'd3, 8'b01_00_0000);
    set_ce(1, 16'h2222);
    rd(2'd1);
    wr(2'd3, 8'b01_11_000_0);
    rd(2'd1);
    check("R10 freeze cancelled", {8'd0, q}, 16'h0022);
    rd(2'd1);
    check("R10 read pos reset", {8'd0, q}, 16'h0022);
  endtask

  task automatic t_ctl_read;
    rd(2'd3);
    check("R11 oe", {15'd0, oe}, 16'd0);
    check("R11 dout", {8'd0, q}, 16'd0);
  endtask

  task automatic t_deselect;
    logic [7:0] t; logic te;
    wr(2'd3, 8'b00_11_000_0);
    cyc(1'b1, 1'b1, 1'b0, 2'd0, 8'h55, t, te);
    check("R1 no load", {13'd0, load_o}, 16'd0);
    cyc(1'b1, 1'b1, 1'b0, 2'd3, 8'b00_01_000_0, t, te);
    check("R1 no cfg", {13'd0, cfg_strobe}, 16'd0);
    wr(2'd0, 8'h10);
    wr(2'd0, 8'h20);
    check("R1 write pos unmoved", cr_of(0), 16'h2010);
    set_ce(0, 16'h4321);
    cyc(1'b1, 1'b0, 1'b1, 2'd0, 8'h00, t, te);
    check("R1 no oe", {15'd0, te}, 16'd0);
    rd(2'd0);
    check("R1 read pos unmoved", {8'd0, q}, 16'h0021);
    rd(2'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_writes();
    t_interleave();
    t_read();
    t_freeze();
    t_refreeze();
    t_single_read();
    t_mixed_dir();
    t_reconfig();
    t_ctl_read();
    t_deselect();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule